// File: doc/BRIEF.md
# Dual GPIO Port Register Bank

This block is one logical device of a configuration space. It holds two general purpose I/O ports, each eight bits wide. The second port is narrower by default and has five implemented pins. A host reaches the bank through a strobed register interface with an 8-bit index. Writes take effect on the clock edge that samples them. A read returns its value in `reg_rdata` one cycle after the read strobe.

Each port has four controls:
- a direction register;
- a data register;
- a polarity-inversion register;
- an enable bit, kept in a shared enable register.

The driver type of each port, push-pull or open-drain, is one bit in a separate mode register. The first port also depends on a pin-function field. Its pins reach the pads only when that field selects general purpose I/O.

The block produces a per-pin output value and output enable, and it samples the pin levels for reads. Inversion sits between the pin and the data register in both directions. A port is blocked from driving its pads by any of three conditions: its enable bit is clear, the external ownership claim for that port is raised, or, for the first port, the pin-function field selects another function.

Top module: `gpio_bank_pair`

## Requirements
- R1: After reset, every implemented direction bit is 1 and all data and inversion bits are 0. The enable, driver mode and pin-function registers read 0. No pin has its output enable set, `pin_out` is 0 and `reg_rdata` is 0.
- R2: Index 0x30 holds the port enables: bit 0 is the first port and bit 1 is the second port. Bits above 1 read as 0. While a port's enable bit is 0, none of its pins is driven and a read of its data index returns 0.
- R3: The first port's direction, data and inversion registers are at 0xE0, 0xE1 and 0xE2. The second port's are at 0xE4, 0xE5 and 0xE6. Direction and inversion read back what was written. The data index reads back as described in R8.
- R4: A direction bit of 1 makes the pin an input, which is never driven. A direction bit of 0 makes the pin an output.
- R5: In push-pull mode, an output pin of an active port has its output enable set, and `pin_out` equals the data bit XOR the inversion bit.
- R6: In open-drain mode, `pin_out` is always 0. An output pin's output enable is set only while its data XOR inversion value is 0.
- R7: The driver mode register is at index 0x29. Bit 3 selects the first port's mode and bit 4 selects the second port's. A bit value of 1 means push-pull and 0 means open-drain.
- R8: A read of the data index of an enabled port returns, per pin, the pin level XOR the inversion bit for input pins, and the stored data bit for output pins.
- R9: The second port has five pins, in bits 4:0. Bits 7:5 of its direction, data and inversion registers read 0 whatever was written, and pins 7:5 of that port are never driven.
- R10: The pin-function field is bits 1:0 of the register at index 0x2C. The first port's pins are driven only while this field equals 2. The values 0, 1 and 3 block them.
- R11: While `pin_claim[p]` is 1, no pin of port p is driven. The port's registers keep their values.
- R12: `reg_rdata` carries the addressed value exactly one cycle after `reg_re` and is 0 in any cycle not following a read. Unassigned indices read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_re` |
| pin_claim | input | 2 | Per-port external ownership claim; blocks driving |
| pin_in | input | 16 | Sampled pin levels, first port in bits 7:0 |
| pin_out | output | 16 | Output value per pin |
| pin_oe | output | 16 | Output enable per pin |

## Verification
Most of the state feeds the pads through combinational logic, so a wrong enable, mode, function or direction bit shows on `pin_oe` or `pin_out` in the cycle after the write that set it. The bench checks the pads right after each configuration change. A wrong inversion or data bit shows in two places: on the pad value of output pins, and in data-index reads of input pins one cycle after the read strobe. Storage leaking into the three missing pins of the narrow port surfaces as nonzero upper bits on readback or on its output enables.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int REG_W = 8;
    localparam int IDX_W = 8;
    localparam logic [1:0] FUNC_GPIO = 2'd2;

    typedef struct packed {
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] data;
        logic [REG_W-1:0] inv;
    } port_regs_t;

    typedef struct packed {
        logic [REG_W-1:0] enable;
        logic [REG_W-1:0] drive_mode;
        logic [REG_W-1:0] pin_func;
        logic [REG_W-1:0] rdata;
    } glob_regs_t;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bank_pkg::*;
#(
    parameter int              PINS    = 8,
    parameter logic [IDX_W-1:0] IDX_DIR = 8'hE0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    output port_regs_t       regs
);
    localparam logic [REG_W-1:0] PIN_MASK = {REG_W{1'b1}} >> (REG_W - PINS);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_DIR + 8'd1;
    localparam logic [IDX_W-1:0] IDX_INV  = IDX_DIR + 8'd2;

    port_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_idx == IDX_DIR)  r_d.dir  = wr_data & PIN_MASK;
            if (wr_idx == IDX_DATA) r_d.data = wr_data & PIN_MASK;
            if (wr_idx == IDX_INV)  r_d.inv  = wr_data & PIN_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.dir  <= PIN_MASK;
            r_q.data <= '0;
            r_q.inv  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;

    // Registers change only on a write strobe
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(r_q));

    // A write to the direction index lands, masked to implemented pins
    p_dir_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_DIR) |=> r_q.dir == ($past(wr_data) & PIN_MASK));
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 8
) (
    input  port_regs_t       regs,
    input  logic             enabled,
    input  logic             active,
    input  logic             push_pull,
    input  logic [REG_W-1:0] pin_in,
    output logic [REG_W-1:0] pin_out,
    output logic [REG_W-1:0] pin_oe,
    output logic [REG_W-1:0] rd_val
);
    localparam logic [REG_W-1:0] PIN_MASK = {REG_W{1'b1}} >> (REG_W - PINS);

    logic [REG_W-1:0] level;
    logic [REG_W-1:0] want;

    always_comb begin
        level   = regs.data ^ regs.inv;
        want    = ~regs.dir & PIN_MASK & {REG_W{active}};
        pin_oe  = push_pull ? want : (want & ~level);
        pin_out = push_pull ? (level & pin_oe) : '0;
        rd_val  = enabled
                ? (((regs.dir & (pin_in ^ regs.inv)) | (~regs.dir & regs.data)) & PIN_MASK)
                : '0;
    end
endmodule

// File: rtl/gpio_bank_pair.sv
module gpio_bank_pair
    import gpio_bank_pkg::*;
#(
    parameter int               NARROW_PINS = 5,
    parameter logic [IDX_W-1:0] IDX_EN      = 8'h30,
    parameter logic [IDX_W-1:0] IDX_DRV     = 8'h29,
    parameter logic [IDX_W-1:0] IDX_FUNC    = 8'h2C,
    parameter logic [IDX_W-1:0] BASE_A      = 8'hE0,
    parameter logic [IDX_W-1:0] BASE_B      = 8'hE4,
    parameter int               DRV_BIT_A   = 3,
    parameter int               DRV_BIT_B   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [7:0]  reg_idx,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [1:0]  pin_claim,
    input  logic [15:0] pin_in,
    output logic [15:0] pin_out,
    output logic [15:0] pin_oe
);
    localparam int NPORTS = 2;
    localparam logic [REG_W-1:0] EN_MASK = {REG_W{1'b1}} >> (REG_W - NPORTS);

    glob_regs_t g_d, g_q;
    port_regs_t       regs   [NPORTS];
    logic [REG_W-1:0] rd_val [NPORTS];
    logic [NPORTS-1:0] active, push_pull;
    logic [REG_W-1:0] rd_mux;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int               PINS = (p == 0) ? REG_W : NARROW_PINS;
        localparam logic [IDX_W-1:0] BASE = (p == 0) ? BASE_A : BASE_B;
        localparam int               DBIT = (p == 0) ? DRV_BIT_A : DRV_BIT_B;

        if (p == 0) begin : g_func_gate
            assign active[p] = g_q.enable[p] & ~pin_claim[p]
                             & (g_q.pin_func[1:0] == FUNC_GPIO);
        end else begin : g_plain
            assign active[p] = g_q.enable[p] & ~pin_claim[p];
        end
        assign push_pull[p] = g_q.drive_mode[DBIT];

        gpio_port_regs #(.PINS(PINS), .IDX_DIR(BASE)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we),
            .wr_idx  (reg_idx),
            .wr_data (reg_wdata),
            .regs    (regs[p])
        );

        gpio_pin_drive #(.PINS(PINS)) u_drive (
            .regs      (regs[p]),
            .enabled   (g_q.enable[p]),
            .active    (active[p]),
            .push_pull (push_pull[p]),
            .pin_in    (pin_in[p*REG_W +: REG_W]),
            .pin_out   (pin_out[p*REG_W +: REG_W]),
            .pin_oe    (pin_oe[p*REG_W +: REG_W]),
            .rd_val    (rd_val[p])
        );

        // A cleared enable bit leaves the whole port undriven
        p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !g_q.enable[p] |-> pin_oe[p*REG_W +: REG_W] == '0);

        // An external claim leaves the whole port undriven
        p_claim_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
            pin_claim[p] |-> pin_oe[p*REG_W +: REG_W] == '0);

        // Open-drain never drives a high value
        p_od_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !push_pull[p] |-> pin_out[p*REG_W +: REG_W] == '0);
    end

    always_comb begin
        rd_mux = '0;
        case (reg_idx)
            IDX_EN:           rd_mux = g_q.enable;
            IDX_DRV:          rd_mux = g_q.drive_mode;
            IDX_FUNC:         rd_mux = g_q.pin_func;
            BASE_A:           rd_mux = regs[0].dir;
            BASE_A + 8'd1:    rd_mux = rd_val[0];
            BASE_A + 8'd2:    rd_mux = regs[0].inv;
            BASE_B:           rd_mux = regs[1].dir;
            BASE_B + 8'd1:    rd_mux = rd_val[1];
            BASE_B + 8'd2:    rd_mux = regs[1].inv;
            default:          rd_mux = '0;
        endcase
    end

    always_comb begin
        g_d       = g_q;
        g_d.rdata = '0;
        if (reg_we) begin
            if (reg_idx == IDX_EN)   g_d.enable     = reg_wdata & EN_MASK;
            if (reg_idx == IDX_DRV)  g_d.drive_mode = reg_wdata;
            if (reg_idx == IDX_FUNC) g_d.pin_func   = reg_wdata;
        end
        if (reg_re) g_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign reg_rdata = g_q.rdata;

    // Read data is quiet in any cycle not following a read strobe
    p_rdata_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> reg_rdata == '0);

    // First port stays off the pads unless the function field selects GPIO
    p_func_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.pin_func[1:0] != FUNC_GPIO) |-> pin_oe[REG_W-1:0] == '0);

    // Missing pins of the narrow port are never driven
    p_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[2*REG_W-1:REG_W+NARROW_PINS] == '0);
endmodule

// File: tb/gpio_bank_pair_test.sv
`timescale 1ns/1ps
module gpio_bank_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [7:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [1:0]  pin_claim = '0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int tests = 0;
    int failed = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    gpio_bank_pair uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_claim(pin_claim), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] val);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        reg_re = 1'b1; reg_idx = idx;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic pins(input logic [15:0] eout, input logic [15:0] eoe, input string tag);
        chk(pin_out, eout, {tag, " pin_out"});
        chk(pin_oe, eoe, {tag, " pin_oe"});
    endtask

    // Monitor: pops the expected read value one cycle after each read strobe
    initial begin
        forever begin
            bit fired;
            @(posedge clk);
            fired = reg_re;
            @(negedge clk);
            if (fired) begin
                if (exp_q.size() == 0) begin
                    chk(reg_rdata, 16'hxxxx, "R12 unexpected read");
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({8'h00, reg_rdata}, {8'h00, e}, t);
                end
            end else if (rst_n) begin
                chk({8'h00, reg_rdata}, 16'h0000, "R12 quiet rdata");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; failed++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        pins(16'h0000, 16'h0000, "R1 reset pins");
        chk({8'h00, reg_rdata}, 16'h0000, "R1 reset rdata");
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'hE0, 8'hFF, "R1 dir A reset");
        rd(8'hE4, 8'h1F, "R1 R9 dir B reset");
        rd(8'hE1, 8'h00, "R1 data A reset");
        rd(8'hE6, 8'h00, "R1 inv B reset");
        rd(8'h30, 8'h00, "R1 enable reset");
        rd(8'h29, 8'h00, "R1 mode reset");
        rd(8'h2C, 8'h00, "R1 func reset");

        // Bring the first port up in push-pull
        wr(8'h2C, 8'h02);
        wr(8'h30, 8'h03);
        wr(8'h29, 8'h18);
        wr(8'hE2, 8'h0F);
        wr(8'hE1, 8'h33);
        pins(16'h0000, 16'h0000, "R4 all inputs");
        wr(8'hE0, 8'hF0);
        pins(16'h000C, 16'h000F, "R4 R5 push-pull");
        rd(8'hE0, 8'hF0, "R3 dir A");
        rd(8'hE2, 8'h0F, "R3 inv A");
        pin_in = 16'h00A5;
        rd(8'hE1, 8'hA3, "R8 mixed data read");
        rd(8'h2C, 8'h02, "R10 func readback");

        // Open-drain on the first port
        wr(8'h29, 8'h10);
        pins(16'h0000, 16'h0003, "R6 R7 open-drain A");
        rd(8'h29, 8'h10, "R7 mode readback");
        wr(8'h29, 8'h18);
        pins(16'h000C, 16'h000F, "R7 back to push-pull");

        // Pin function gate
        wr(8'h2C, 8'h01);
        pins(16'h0000, 16'h0000, "R10 func=1 blocks");
        wr(8'h2C, 8'h03);
        pins(16'h0000, 16'h0000, "R10 func=3 blocks");
        wr(8'h2C, 8'h02);
        pins(16'h000C, 16'h000F, "R10 func=2 drives");

        // External claim
        pin_claim = 2'b01;
        @(negedge clk);
        pins(16'h0000, 16'h0000, "R11 claim blocks");
        rd(8'hE0, 8'hF0, "R11 regs kept");
        pin_claim = 2'b00;
        @(negedge clk);
        pins(16'h000C, 16'h000F, "R11 claim released");

        // Enable gate
        wr(8'h30, 8'h02);
        pins(16'h0000, 16'h0000, "R2 disabled port");
        rd(8'hE1, 8'h00, "R2 disabled data read");
        wr(8'h30, 8'hFF);
        rd(8'h30, 8'h03, "R2 enable upper bits");
        pins(16'h000C, 16'h000F, "R2 re-enabled");

        // Narrow second port
        wr(8'hE5, 8'hFF);
        wr(8'hE4, 8'h00);
        rd(8'hE4, 8'h00, "R3 dir B");
        rd(8'hE5, 8'h1F, "R9 data B masked");
        pins(16'h1F0C, 16'h1F0F, "R9 R5 narrow push-pull");
        wr(8'hE6, 8'hFF);
        rd(8'hE6, 8'h1F, "R9 inv B masked");
        pins(16'h000C, 16'h1F0F, "R5 inverted B");
        wr(8'h29, 8'h08);
        pins(16'h000C, 16'h1F0F, "R6 R7 open-drain B low");
        wr(8'hE6, 8'h00);
        pins(16'h000C, 16'h000F, "R6 open-drain B released");
        wr(8'hE4, 8'hFF);
        rd(8'hE4, 8'h1F, "R9 dir B upper zero");
        pin_in = 16'hFFA5;
        rd(8'hE5, 8'h1F, "R8 R9 input read B");

        // Unassigned indices
        rd(8'h55, 8'h00, "R12 unknown index");
        rd(8'hE3, 8'h00, "R12 gap index");

        repeat (2) @(negedge clk);
        chk(16'(exp_q.size()), 16'h0000, "R12 all reads returned");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule